// File: doc/BRIEF.md
# Configurable Fixed-Point Multiplier

The block multiplies two W-bit operands (W = 32 by default) into a double-length 2W-bit product. Each operand carries two mode bits, signed and fractional, so it can be treated as an unsigned integer, a signed integer, an unsigned fraction or a signed fraction. When both operands are signed fractions (1.(W-1) format), the raw product has a redundant sign bit. The block shifts it left by one bit to re-align it. The one operand pair whose true result is +1 cannot be represented, so that result is clamped to the largest positive value.

An output-select field returns one of four views of the aligned product: the full double-length value, its high half, its low half, or a single-length value rounded half-up. Operands, mode bits and the select are captured on a clock edge where `in_valid_i` is high. The result and the overflow flag appear with `out_valid_o` on the next cycle and stay unchanged until the next capture.

Top module: `fxp_mul`

## Requirements
- R1: With either operand marked integer, and in every mode without the alignment shift, the full product (select 0) equals the exact product of the two interpreted operands, taken modulo 2^(2W).
- R2: Each operand is interpreted on its own. When its signed bit is 1, its most significant bit is a sign bit of weight -2^(W-1). When its signed bit is 0, that bit has weight +2^(W-1).
- R3: When both operands are signed and both are fractional, the product is shifted left by one bit. The top bit is dropped and the result is filled with a zero at bit 0.
- R4: No alignment shift is applied when at least one operand is integer, or when at least one fractional operand is unsigned.
- R5: When both operands are signed fractions equal to 2^(W-1) (bit pattern 1 followed by zeros), the aligned product saturates to 2^(2W-1)-1 and `overflow_o` is 1, whatever the select.
- R6: Select encodings: 0 gives the full 2W-bit product. 1 gives the high half in bits W-1:0 with the upper half zero. 2 gives the low half in bits W-1:0 with the upper half zero. 3 gives the rounded value in bits W-1:0 with the upper half zero.
- R7: Rounding (select 3) adds 2^(W-1) to the aligned product and keeps bits 2W-1:W. When either operand is signed and this carry would turn a positive value negative, the result saturates to 2^(W-1)-1 and `overflow_o` is 1.
- R8: `out_valid_o`, `result_o` and `overflow_o` reflect operands captured on the previous rising edge where `in_valid_i` was 1. After an edge with `in_valid_i` at 0, `out_valid_o` and `overflow_o` are 0 and `result_o` keeps its value.
- R9: While `rst_ni` is low, `out_valid_o` and `overflow_o` are 0 and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Capture operands, modes and select |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| a_signed_i | input | 1 | First operand is two's complement |
| a_frac_i | input | 1 | First operand is fractional |
| b_signed_i | input | 1 | Second operand is two's complement |
| b_frac_i | input | 1 | Second operand is fractional |
| out_sel_i | input | 2 | View select: 0 full, 1 high, 2 low, 3 rounded |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 2W | Selected result |
| overflow_o | output | 1 | A saturation happened in this result |

## Verification
The fractional corner saturation and the rounding carry saturation can occur in the same cycle. Clamping 2^(W-1) times 2^(W-1) gives an all-ones low half, so the rounding carry then spills into the sign. The bench sends this corner pair with select 3 and expects exactly 2^(W-1)-1 with a single overflow indication. It then sends the same pair with selects 0, 1 and 2 to check that the clamp alone is visible in each view. Back-to-back valid cycles are mixed with idle gaps, so the hold behaviour is judged directly after a saturated result.

// File: rtl/fxp_mul_pkg.sv
package fxp_mul_pkg;
  typedef enum logic [1:0] {
    SEL_FULL = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_LOW  = 2'd2,
    SEL_RND  = 2'd3
  } out_sel_e;

  typedef struct packed {
    logic is_signed;
    logic is_frac;
  } opmode_t;
endpackage

// File: rtl/fxp_mul_core.sv
module fxp_mul_core
  import fxp_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  opmode_t        ma_i,
  input  opmode_t        mb_i,
  output logic [2*W-1:0] prod_o
);
  localparam int XW = 2 * W + 2;

  logic [W-1:0] op  [2];
  opmode_t      md  [2];
  logic [XW-1:0] ext [2];
  logic [XW-1:0] full;

  assign op[0] = a_i;
  assign op[1] = b_i;
  assign md[0] = ma_i;
  assign md[1] = mb_i;

  // sign or zero extend each operand to the full product width
  for (genvar g = 0; g < 2; g++) begin : g_ext
    assign ext[g] = {{(W + 2){md[g].is_signed & op[g][W-1]}}, op[g]};
  end

  assign full   = ext[0] * ext[1];
  assign prod_o = full[2*W-1:0];
endmodule

// File: rtl/fxp_mul_align.sv
module fxp_mul_align
  import fxp_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  opmode_t        ma_i,
  input  opmode_t        mb_i,
  input  logic [2*W-1:0] prod_i,
  output logic           shift_o,
  output logic           sat_o,
  output logic [2*W-1:0] aligned_o
);
  localparam logic [W-1:0]   MIN_NEG = {1'b1, {(W - 1){1'b0}}};
  localparam logic [2*W-1:0] MAX_POS = {1'b0, {(2 * W - 1){1'b1}}};

  logic corner;

  assign shift_o = ma_i.is_frac & mb_i.is_frac & ma_i.is_signed & mb_i.is_signed;
  assign corner  = (a_i == MIN_NEG) && (b_i == MIN_NEG);
  assign sat_o   = shift_o & corner;

  always_comb begin
    if (sat_o)        aligned_o = MAX_POS;
    else if (shift_o) aligned_o = {prod_i[2*W-2:0], 1'b0};
    else              aligned_o = prod_i;
  end
endmodule

// File: rtl/fxp_mul_round.sv
module fxp_mul_round
  import fxp_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0] aligned_i,
  input  logic           sgn_i,
  input  out_sel_e       sel_i,
  output logic           rsat_o,
  output logic [2*W-1:0] res_o
);
  localparam logic [2*W:0]   HALF    = {{(W + 1){1'b0}}, 1'b1, {(W - 1){1'b0}}};
  localparam logic [W-1:0]   MAX_S   = {1'b0, {(W - 1){1'b1}}};
  localparam logic [W-1:0]   ZERO_W  = '0;

  logic [2*W:0] sum;
  logic [W-1:0] rnd;
  logic         carry_ovf;

  assign sum = {1'b0, aligned_i} + HALF;
  // unsigned W x W products top out below the carry point, so only signed can wrap
  assign carry_ovf = sgn_i & ~aligned_i[2*W-1] & sum[2*W-1];
  assign rsat_o    = (sel_i == SEL_RND) & carry_ovf;
  assign rnd       = carry_ovf ? MAX_S : sum[2*W-1:W];

  always_comb begin
    unique case (sel_i)
      SEL_FULL: res_o = aligned_i;
      SEL_HIGH: res_o = {ZERO_W, aligned_i[2*W-1:W]};
      SEL_LOW:  res_o = {ZERO_W, aligned_i[W-1:0]};
      default:  res_o = {ZERO_W, rnd};
    endcase
  end
endmodule

// File: rtl/fxp_mul.sv
module fxp_mul
  import fxp_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           a_signed_i,
  input  logic           a_frac_i,
  input  logic           b_signed_i,
  input  logic           b_frac_i,
  input  logic [1:0]     out_sel_i,
  output logic           out_valid_o,
  output logic [2*W-1:0] result_o,
  output logic           overflow_o
);
  localparam logic [2*W-1:0] MAX_POS = {1'b0, {(2 * W - 1){1'b1}}};

  logic [W-1:0]   a_q, b_q;
  opmode_t        ma_q, mb_q;
  out_sel_e       sel_q;
  logic           vld_q;
  logic [2*W-1:0] prod, aligned, res;
  logic           shift, sat, rsat;

  // operands are captured; the arithmetic settles from the registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      ma_q  <= '0;
      mb_q  <= '0;
      sel_q <= SEL_FULL;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) begin
        a_q   <= a_i;
        b_q   <= b_i;
        ma_q  <= '{is_signed: a_signed_i, is_frac: a_frac_i};
        mb_q  <= '{is_signed: b_signed_i, is_frac: b_frac_i};
        sel_q <= out_sel_e'(out_sel_i);
      end
    end
  end

  fxp_mul_core #(.W(W)) u_core (
    .a_i    (a_q),
    .b_i    (b_q),
    .ma_i   (ma_q),
    .mb_i   (mb_q),
    .prod_o (prod)
  );

  fxp_mul_align #(.W(W)) u_align (
    .a_i       (a_q),
    .b_i       (b_q),
    .ma_i      (ma_q),
    .mb_i      (mb_q),
    .prod_i    (prod),
    .shift_o   (shift),
    .sat_o     (sat),
    .aligned_o (aligned)
  );

  fxp_mul_round #(.W(W)) u_round (
    .aligned_i (aligned),
    .sgn_i     (ma_q.is_signed | mb_q.is_signed),
    .sel_i     (sel_q),
    .rsat_o    (rsat),
    .res_o     (res)
  );

  assign out_valid_o = vld_q;
  assign result_o    = res;
  assign overflow_o  = vld_q & (sat | rsat);

  // R8
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && !overflow_o && $stable(result_o)));

  // R5
  corner_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && sat && sel_q == SEL_FULL) |-> (result_o == MAX_POS && overflow_o));

  // R3
  redundant_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift && !sat) |-> (prod[2*W-1] == prod[2*W-2]));

  // R3
  frac_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && shift && !sat && sel_q == SEL_FULL) |-> !result_o[0]);

  // R7
  rnd_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && rsat) |-> (overflow_o && result_o[2*W-1:W-1] == '0));
endmodule

// File: tb/fxp_mul_test.sv
module fxp_mul_test;
  localparam int W = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic          in_valid_i = 1'b0;
  logic [31:0]   a_i = '0, b_i = '0;
  logic          a_signed_i = 1'b0, a_frac_i = 1'b0, b_signed_i = 1'b0, b_frac_i = 1'b0;
  logic [1:0]    out_sel_i = '0;
  logic          out_valid_o;
  logic [63:0]   result_o;
  logic          overflow_o;

  always #10 clk_i = ~clk_i;

  fxp_mul #(.W(W)) uut (
    .clk_i, .rst_ni, .in_valid_i, .a_i, .b_i,
    .a_signed_i, .a_frac_i, .b_signed_i, .b_frac_i,
    .out_sel_i, .out_valid_o, .result_o, .overflow_o
  );

  typedef struct {
    logic [63:0] res;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_run = 0, n_fail = 0;
  logic [63:0] last_res = '0;
  bit          done = 1'b0;

  function automatic void ref_calc(input logic [31:0] a, b, input bit as, af, bs, bf,
                                   input logic [1:0] sel, output logic [63:0] res,
                                   output logic ovf);
    logic [63:0]        ae, be, p;
    logic signed [64:0] s, q;
    logic [64:0]        u;
    ae  = as ? {{32{a[31]}}, a} : {32'b0, a};
    be  = bs ? {{32{b[31]}}, b} : {32'b0, b};
    p   = ae * be;
    ovf = 1'b0;
    if (as && bs && af && bf) begin
      if (a == 32'h8000_0000 && b == 32'h8000_0000) begin
        p   = 64'h7FFF_FFFF_FFFF_FFFF;
        ovf = 1'b1;
      end else p = p << 1;
    end
    case (sel)
      2'd0: res = p;
      2'd1: res = {32'b0, p[63:32]};
      2'd2: res = {32'b0, p[31:0]};
      default: begin
        if (as || bs) begin
          s = $signed({p[63], p}) + 65'sd2147483648;
          q = s >>> 32;
          if (q > 65'sd2147483647) begin
            res = {32'b0, 32'h7FFF_FFFF};
            ovf = 1'b1;
          end else res = {32'b0, q[31:0]};
        end else begin
          u   = {1'b0, p} + 65'd2147483648;
          res = {32'b0, u[63:32]};
        end
      end
    endcase
  endfunction

  task automatic send(input logic [31:0] a, b, input bit as, af, bs, bf,
                      input logic [1:0] sel, input string tag);
    exp_t e;
    @(negedge clk_i);
    a_i = a; b_i = b; a_signed_i = as; a_frac_i = af; b_signed_i = bs; b_frac_i = bf;
    out_sel_i = sel; in_valid_i = 1'b1;
    ref_calc(a, b, as, af, bs, bf, sel, e.res, e.ovf);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic go_idle();
    @(negedge clk_i);
    in_valid_i = 1'b0;
    a_i = $urandom(); b_i = $urandom(); out_sel_i = 2'(($urandom() % 4));
  endtask

  // monitor: compare each valid result against the oldest expected item
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      n_run++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R8: unexpected out_valid, result %h", result_o);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (result_o !== e.res || overflow_o !== e.ovf) begin
          n_fail++;
          $display("FAIL %s: got %h ovf %b, expected %h ovf %b", e.tag, result_o, overflow_o,
                   e.res, e.ovf);
        end
      end
      last_res = result_o;
    end
  end

  task automatic check_idle(input string tag);
    @(negedge clk_i);
    n_run++;
    if (out_valid_o !== 1'b0 || overflow_o !== 1'b0 || result_o !== last_res) begin
      n_fail++;
      $display("FAIL %s: idle got vld %b ovf %b res %h, expected 0 0 %h", tag, out_valid_o,
               overflow_o, result_o, last_res);
    end
  endtask

  function automatic logic [31:0] pick();
    case ($urandom() % 6)
      0: return 32'h0;
      1: return 32'h8000_0000;
      2: return 32'h7FFF_FFFF;
      3: return 32'hFFFF_FFFF;
      4: return 32'h1;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    n_run++;
    if (out_valid_o !== 1'b0 || overflow_o !== 1'b0 || result_o !== 64'h0) begin
      n_fail++;
      $display("FAIL R9: reset got vld %b ovf %b res %h, expected 0 0 0", out_valid_o,
               overflow_o, result_o);
    end
    rst_ni = 1'b1;

    // R5 corner in every view; R7 rounding carry on top of the clamp
    send(32'h8000_0000, 32'h8000_0000, 1, 1, 1, 1, 2'd0, "R5");
    send(32'h8000_0000, 32'h8000_0000, 1, 1, 1, 1, 2'd1, "R5");
    send(32'h8000_0000, 32'h8000_0000, 1, 1, 1, 1, 2'd2, "R5");
    send(32'h8000_0000, 32'h8000_0000, 1, 1, 1, 1, 2'd3, "R7");
    go_idle();
    check_idle("R8");
    check_idle("R8");
    // R1 integer: no shift, no clamp
    send(32'h8000_0000, 32'h8000_0000, 1, 0, 1, 0, 2'd0, "R1");
    send(32'h0, 32'h8000_0000, 1, 1, 1, 1, 2'd0, "R1");
    send(32'h1234_5678, 32'h9ABC_DEF0, 0, 0, 0, 0, 2'd0, "R1");
    // R4 mixed and unsigned fractional
    send(32'h8000_0000, 32'h8000_0000, 1, 1, 1, 0, 2'd0, "R4");
    send(32'h8000_0000, 32'h8000_0000, 0, 1, 0, 1, 2'd0, "R4");
    send(32'h8000_0000, 32'h8000_0000, 1, 1, 0, 1, 2'd0, "R4");
    // R3 maximum positive fractions
    send(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 1, 1, 1, 2'd0, "R3");
    send(32'h7FFF_FFFF, 32'h8000_0000, 1, 1, 1, 1, 2'd0, "R3");
    // R2 per-operand signedness
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 2'd0, "R2");
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0, 0, 2'd0, "R2");
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1, 0, 2'd0, "R2");
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 1, 0, 2'd0, "R2");
    // R6 views
    send(32'h1234_5678, 32'h9ABC_DEF0, 1, 0, 0, 0, 2'd1, "R6");
    send(32'h1234_5678, 32'h9ABC_DEF0, 1, 0, 0, 0, 2'd2, "R6");
    // R7 exact half rounds up, and plain rounding
    send(32'hFFFF_FFFF, 32'h8000_0000, 1, 0, 0, 0, 2'd3, "R7");
    send(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 1, 1, 1, 2'd3, "R7");
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, 0, 1, 2'd3, "R7");
    go_idle();
    check_idle("R8");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = pick();
      rb = pick();
      send(ra, rb, 1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
           2'($urandom() % 4), "R1");
      if ($urandom() % 5 == 0) begin
        go_idle();
        check_idle("R8");
      end
    end
    go_idle();
    repeat (3) @(negedge clk_i);
    n_run++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R8: %0d results missing, expected 0", sb.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule